// File: doc/BRIEF.md
# Fetch-Stage Instruction Skip Injector

This block emulates instruction-skip faults at the fetch stage of a simple in-order core that uses fixed 32-bit instructions. It sits between the core's program counter and instruction memory. The core presents a fetch address and a fetch strobe. For each fetch, the block either passes the request to memory or holds it back. It keeps a one-entry instruction buffer and sends one instruction per cycle toward the decode queue. When a fetch is suppressed, the buffer keeps its old word, so the instruction from the previous slot is issued a second time. The core keeps stepping its PC by 4 on every slot, so the suppressed word is never read.

Injection begins only after arming. A trigger address must first be fetched a programmed number of times. After that, a small table decides per address whether each occurrence is skipped or executed. An entry with no actions skips every occurrence. Otherwise the entry works through an ordered list of "skip k" and "execute k" actions, and once the list is used up its address runs normally. The table and the trigger are loaded through a write port while the block is disarmed. Two status pulses report arming and each skipped fetch.

Top module: `fetch_skip_injector`

## Requirements
- R1: After synchronous active-low reset, `armed`, `armed_pulse`, `skip_pulse` and `issue_valid` are 0, and `issue_instr` holds the filler word 32'h0000_0013.
- R2: Configuration writes take effect only while `armed` is 0, and are ignored once it is 1. Ops are selected by `cfg_op`: 0 loads the trigger (`cfg_addr` is the address, `cfg_count` is N); 1 loads a header for entry `cfg_entry` (`cfg_addr` is the address, `cfg_count` is the number of actions, and values above 4 are clipped to 4); 2 loads action `cfg_slot` of entry `cfg_entry` (`cfg_kind` 1 means skip and 0 means execute, `cfg_count` is k).
- R3: `armed` rises at the clock edge that ends the Nth valid fetch of the trigger address (N=0 behaves as 1). `armed_pulse` is 1 for exactly that first armed cycle, and `armed` stays 1 until reset.
- R4: While disarmed, `mem_req` equals `fetch_valid` and `mem_addr` equals `fetch_pc`, and no table entry consumes an occurrence.
- R5: A skipped fetch holds `mem_req` at 0 in its own cycle. In the next cycle `skip_pulse` is 1 and `issue_instr` repeats the previously issued word.
- R6: `issue_valid` follows `fetch_valid` one cycle later, and after a forwarded fetch `issue_instr` equals that cycle's `mem_rdata`.
- R7: An armed fetch whose address matches an entry that has zero actions is skipped on every occurrence.
- R8: An entry with actions consumes them in slot order, one valid armed fetch of its address per occurrence. Each action lasts k occurrences, and k=0 behaves as 1.
- R9: Once an entry's action list is used up, every later fetch of its address is forwarded normally.
- R10: If several entries hold the fetch address, only the lowest-indexed one decides and advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | 0 trigger, 1 entry header, 2 entry action |
| cfg_entry | input | 3 | Table entry index |
| cfg_slot | input | 2 | Action slot index |
| cfg_kind | input | 1 | Action kind: 1 skip, 0 execute |
| cfg_addr | input | 32 | Trigger or entry address |
| cfg_count | input | 16 | N, action count, or k |
| fetch_valid | input | 1 | Core fetch strobe |
| fetch_pc | input | 32 | Core fetch address |
| mem_req | output | 1 | Request to instruction memory |
| mem_addr | output | 32 | Memory fetch address |
| mem_rdata | input | 32 | Memory read word, same cycle as the request |
| issue_valid | output | 1 | Instruction valid toward decode |
| issue_instr | output | 32 | Instruction toward decode (buffer content) |
| armed | output | 1 | Injection enabled |
| armed_pulse | output | 1 | One-cycle pulse on arming |
| skip_pulse | output | 1 | One-cycle pulse per skipped fetch |

## Verification
A wrong action pointer or occurrence counter inside an entry does not show up at once. It appears only at the next fetch of that entry's address, as `mem_req` held low where a request was due, or the reverse, and one cycle later as a repeated or fresh `issue_instr` together with `skip_pulse`. A trigger counter that is off by one moves the rise of `armed` by a whole pass over the trigger address. The reference model therefore replays a loop of addresses over many passes, so that every divergence is compared on the very cycle it first reaches a port.

// File: rtl/fsi_pkg.sv
// Shared constants and types for the fetch skip injector.
// Assumes fixed 32-bit instruction words.
package fsi_pkg;
    localparam int unsigned WORD_W = 32;
    localparam logic [WORD_W-1:0] FILLER_WORD = 32'h0000_0013;

    typedef enum logic [1:0] {
        CFG_TRIG = 2'd0,
        CFG_HDR  = 2'd1,
        CFG_ACT  = 2'd2,
        CFG_NONE = 2'd3
    } cfg_op_e;
endpackage

// File: rtl/fsi_trigger.sv
// Arming logic: counts valid fetches of the trigger address and arms
// the injector on the Nth one (N=0 acts as 1). Assumes the trigger is
// loaded while disarmed. Arming is sticky until reset.
module fsi_trigger
    import fsi_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_op,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_count,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_pc,
    output logic          armed,
    output logic          armed_pulse
);
    logic [AW-1:0] trig_addr_q;
    logic [CW-1:0] trig_n_q;
    logic [CW-1:0] tcnt_q;
    logic          armed_q;
    logic          pulse_q;
    logic [CW:0]   thr;
    logic          hit;
    logic          arm_now;

    // Threshold and arming decision for the current fetch.
    always_comb begin
        thr     = (trig_n_q == '0) ? (CW+1)'(1) : {1'b0, trig_n_q};
        hit     = fetch_valid && !armed_q && (fetch_pc == trig_addr_q);
        arm_now = hit && (({1'b0, tcnt_q} + (CW+1)'(1)) >= thr);
    end

    // Trigger registers, occurrence counter and sticky armed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_addr_q <= '0;
            trig_n_q    <= '0;
            tcnt_q      <= '0;
            armed_q     <= 1'b0;
            pulse_q     <= 1'b0;
        end else begin
            pulse_q <= arm_now;
            if (arm_now) begin
                armed_q <= 1'b1;
            end
            if (cfg_we && !armed_q && cfg_op == CFG_TRIG) begin
                trig_addr_q <= cfg_addr;
                trig_n_q    <= cfg_count;
                tcnt_q      <= '0;
            end else if (hit && !arm_now) begin
                tcnt_q <= tcnt_q + CW'(1);
            end
        end
    end

    assign armed       = armed_q;
    assign armed_pulse = pulse_q;
endmodule

// File: rtl/fsi_table.sv
// Per-address action table. Each entry holds an address, an action
// count and up to SLOTS actions (kind, k). While armed, the
// lowest-indexed matching entry decides skip or execute and advances
// its own pointer and occurrence counter. Writes apply only while
// disarmed.
module fsi_table
    import fsi_pkg::*;
#(
    parameter int unsigned AW      = 32,
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned SLOTS   = 4,
    parameter int unsigned CW      = 16,
    localparam int unsigned IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int unsigned SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int unsigned PW     = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_op,
    input  logic [IW-1:0] cfg_entry,
    input  logic [SW-1:0] cfg_slot,
    input  logic          cfg_kind,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_count,
    input  logic          armed,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_pc,
    output logic          skip
);
    logic          valid_q [ENTRIES];
    logic [AW-1:0] addr_q  [ENTRIES];
    logic [PW-1:0] nact_q  [ENTRIES];
    logic [PW-1:0] ptr_q   [ENTRIES];
    logic [CW-1:0] rem_q   [ENTRIES];
    logic          kind_q  [ENTRIES][SLOTS];
    logic [CW-1:0] cnt_q   [ENTRIES][SLOTS];

    logic [IW-1:0] sel;
    logic          any;
    logic [PW-1:0] cur_ptr;
    logic [PW-1:0] cur_nact;
    logic [SW-1:0] slot;
    logic          in_list;
    logic          cur_kind;
    logic [CW:0]   lim;
    logic          last;
    logic          active;
    logic          adv;
    logic [PW-1:0] hdr_nact;

    // Priority match: the lowest index holding the fetch address wins.
    always_comb begin
        sel = '0;
        any = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (valid_q[i] && addr_q[i] == fetch_pc) begin
                sel = IW'(i);
                any = 1'b1;
            end
        end
    end

    // Skip decision and advance condition for the selected entry.
    always_comb begin
        cur_ptr  = ptr_q[sel];
        cur_nact = nact_q[sel];
        in_list  = cur_ptr < cur_nact;
        slot     = cur_ptr[SW-1:0];
        cur_kind = kind_q[sel][slot];
        lim      = (cnt_q[sel][slot] == '0) ? (CW+1)'(1) : {1'b0, cnt_q[sel][slot]};
        last     = ({1'b0, rem_q[sel]} + (CW+1)'(1)) >= lim;
        active   = armed && fetch_valid && any;
        skip     = active && ((cur_nact == '0) || (in_list && cur_kind));
        adv      = active && in_list;
        hdr_nact = (cfg_count > CW'(SLOTS)) ? PW'(SLOTS) : cfg_count[PW-1:0];
    end

    // Table storage: configuration writes and per-entry progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                valid_q[i] <= 1'b0;
                addr_q[i]  <= '0;
                nact_q[i]  <= '0;
                ptr_q[i]   <= '0;
                rem_q[i]   <= '0;
                for (int s = 0; s < SLOTS; s++) begin
                    kind_q[i][s] <= 1'b0;
                    cnt_q[i][s]  <= '0;
                end
            end
        end else if (cfg_we && !armed) begin
            if (cfg_op == CFG_HDR) begin
                valid_q[cfg_entry] <= 1'b1;
                addr_q[cfg_entry]  <= cfg_addr;
                nact_q[cfg_entry]  <= hdr_nact;
                ptr_q[cfg_entry]   <= '0;
                rem_q[cfg_entry]   <= '0;
            end else if (cfg_op == CFG_ACT) begin
                kind_q[cfg_entry][cfg_slot] <= cfg_kind;
                cnt_q[cfg_entry][cfg_slot]  <= cfg_count;
            end
        end else if (adv) begin
            if (last) begin
                ptr_q[sel] <= cur_ptr + PW'(1);
                rem_q[sel] <= '0;
            end else begin
                rem_q[sel] <= rem_q[sel] + CW'(1);
            end
        end
    end
endmodule

// File: rtl/fsi_ibuf.sv
// One-entry instruction buffer. A forwarded fetch loads the memory word.
// A skipped fetch leaves the buffer unchanged, so the prior word is
// reissued. The buffer resets to the filler word, which covers a skip
// that arrives before any load.
module fsi_ibuf
    import fsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic              skip,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              issue_valid,
    output logic [WORD_W-1:0] issue_instr,
    output logic              skip_pulse
);
    logic [WORD_W-1:0] buf_q;
    logic              iv_q;
    logic              sp_q;

    // Buffer load, issue strobe and skip status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= FILLER_WORD;
            iv_q  <= 1'b0;
            sp_q  <= 1'b0;
        end else begin
            iv_q <= fetch_valid;
            sp_q <= fetch_valid && skip;
            if (fetch_valid && !skip) begin
                buf_q <= mem_rdata;
            end
        end
    end

    assign issue_valid = iv_q;
    assign issue_instr = buf_q;
    assign skip_pulse  = sp_q;
endmodule

// File: rtl/fetch_skip_injector.sv
// Top level of the fetch skip injector. Sits between the core fetch
// port and instruction memory. Assumes memory returns mem_rdata in the
// same cycle as mem_req, and that the core steps its PC by 4 per slot.
module fetch_skip_injector
    import fsi_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned SLOTS   = 4,
    parameter int unsigned CW      = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [1:0]                 cfg_op,
    input  logic [$clog2(ENTRIES)-1:0] cfg_entry,
    input  logic [$clog2(SLOTS)-1:0]   cfg_slot,
    input  logic                       cfg_kind,
    input  logic [WORD_W-1:0]          cfg_addr,
    input  logic [CW-1:0]              cfg_count,
    input  logic                       fetch_valid,
    input  logic [WORD_W-1:0]          fetch_pc,
    output logic                       mem_req,
    output logic [WORD_W-1:0]          mem_addr,
    input  logic [WORD_W-1:0]          mem_rdata,
    output logic                       issue_valid,
    output logic [WORD_W-1:0]          issue_instr,
    output logic                       armed,
    output logic                       armed_pulse,
    output logic                       skip_pulse
);
    logic skip;

    fsi_trigger #(.AW(WORD_W), .CW(CW)) trig_u (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op),
        .cfg_addr(cfg_addr), .cfg_count(cfg_count),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .armed(armed), .armed_pulse(armed_pulse)
    );

    fsi_table #(.AW(WORD_W), .ENTRIES(ENTRIES), .SLOTS(SLOTS), .CW(CW)) tbl_u (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op),
        .cfg_entry(cfg_entry), .cfg_slot(cfg_slot), .cfg_kind(cfg_kind),
        .cfg_addr(cfg_addr), .cfg_count(cfg_count), .armed(armed),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .skip(skip)
    );

    fsi_ibuf buf_u (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .skip(skip),
        .mem_rdata(mem_rdata), .issue_valid(issue_valid),
        .issue_instr(issue_instr), .skip_pulse(skip_pulse)
    );

    // Forward the fetch unless the table suppresses it.
    assign mem_req  = fetch_valid && !skip;
    assign mem_addr = fetch_pc;
endmodule

// File: rtl/fsi_chk.sv
// Port-level protocol checks for the fetch skip injector, bound to the top.
module fsi_chk
    import fsi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic              mem_req,
    input logic              issue_valid,
    input logic [WORD_W-1:0] issue_instr,
    input logic              armed,
    input logic              armed_pulse,
    input logic              skip_pulse
);
    // R4
    prearm_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (mem_req == fetch_valid));
    // R5
    req_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> fetch_valid);
    // R5
    skip_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_pulse |-> $past(fetch_valid && !mem_req));
    // R5
    replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_pulse |-> $stable(issue_instr));
    // R3
    armed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);
    // R3
    arm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_pulse |-> (armed && !$past(armed)));
    // R6
    issue_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> $past(fetch_valid));
endmodule

bind fetch_skip_injector fsi_chk chk_u (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .mem_req(mem_req),
    .issue_valid(issue_valid), .issue_instr(issue_instr), .armed(armed),
    .armed_pulse(armed_pulse), .skip_pulse(skip_pulse)
);

// File: tb/fetch_skip_injector_tb_top.sv
module fetch_skip_injector_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_op = 2'd3;
    logic [2:0]  cfg_entry = '0;
    logic [1:0]  cfg_slot = '0;
    logic        cfg_kind = 1'b0;
    logic [31:0] cfg_addr = '0;
    logic [15:0] cfg_count = '0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata;
    logic        issue_valid;
    logic [31:0] issue_instr;
    logic        armed;
    logic        armed_pulse;
    logic        skip_pulse;

    int vectors = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    function automatic logic [31:0] memw(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h0F0F_0000;
    endfunction

    assign mem_rdata = memw(mem_addr);

    fetch_skip_injector dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op),
        .cfg_entry(cfg_entry), .cfg_slot(cfg_slot), .cfg_kind(cfg_kind),
        .cfg_addr(cfg_addr), .cfg_count(cfg_count),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .issue_valid(issue_valid), .issue_instr(issue_instr),
        .armed(armed), .armed_pulse(armed_pulse), .skip_pulse(skip_pulse)
    );

    // Behavioural reference model state.
    bit          m_armed = 0;
    int          m_tcnt = 0;
    logic [31:0] m_trig_addr = '0;
    int          m_trig_n = 0;
    bit          e_valid [8];
    logic [31:0] e_addr [8];
    int          e_nact [8];
    bit          e_kind [8][4];
    int          e_cnt [8][4];
    bit          occ_q [8][$];
    logic [31:0] exp_instr = 32'h0000_0013;
    bit          post_cfg = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] op, input int ent, input int slot,
                             input bit kind, input logic [31:0] addr, input int cnt);
        cfg_we = 1'b1; cfg_op = op; cfg_entry = 3'(ent); cfg_slot = 2'(slot);
        cfg_kind = kind; cfg_addr = addr; cfg_count = 16'(cnt);
        if (!m_armed) begin
            if (op == 2'd0) begin
                m_trig_addr = addr; m_trig_n = cnt; m_tcnt = 0;
            end else if (op == 2'd1) begin
                e_valid[ent] = 1; e_addr[ent] = addr; e_nact[ent] = (cnt > 4) ? 4 : cnt;
            end else if (op == 2'd2) begin
                e_kind[ent][slot] = kind; e_cnt[ent][slot] = cnt;
            end
        end
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; cfg_op = 2'd3;
        chk("R2", "issue_valid after cfg", {31'd0, issue_valid}, 32'd0);
    endtask

    task automatic build_queues();
        for (int i = 0; i < 8; i++) begin
            occ_q[i].delete();
            if (e_valid[i]) begin
                for (int s = 0; s < e_nact[i]; s++) begin
                    int reps = (e_cnt[i][s] == 0) ? 1 : e_cnt[i][s];
                    repeat (reps) occ_q[i].push_back(e_kind[i][s]);
                end
            end
        end
    endtask

    task automatic step(input bit fv, input logic [31:0] pc);
        bit    skip = 0;
        bit    arm_now = 0;
        int    hits = 0;
        int    win = -1;
        string tag = "R6";
        fetch_valid = fv; fetch_pc = pc;
        #1;
        if (fv) begin
            for (int i = 0; i < 8; i++)
                if (e_valid[i] && e_addr[i] == pc) begin
                    hits++;
                    if (win < 0) win = i;
                end
            if (!m_armed) tag = "R4";
            else if (win >= 0) begin
                if (e_nact[win] == 0) begin
                    skip = 1;
                    tag = (post_cfg && win == 0) ? "R2" : "R7";
                end else if (occ_q[win].size() == 0) begin
                    tag = "R9";
                end else begin
                    skip = occ_q[win].pop_front();
                    tag = "R8";
                end
                if (hits > 1) tag = "R10";
            end
            if (!m_armed && pc == m_trig_addr) begin
                m_tcnt++;
                if (m_tcnt >= ((m_trig_n == 0) ? 1 : m_trig_n)) arm_now = 1;
            end
        end
        chk(tag, "mem_req", {31'd0, mem_req}, {31'd0, fv && !skip});
        if (fv) chk(tag, "mem_addr", mem_addr, pc);
        @(posedge clk);
        if (fv && !skip) exp_instr = memw(pc);
        if (arm_now) begin
            m_armed = 1;
            build_queues();
        end
        @(negedge clk);
        chk("R6", "issue_valid", {31'd0, issue_valid}, {31'd0, fv});
        chk(skip ? "R5" : tag, "issue_instr", issue_instr, exp_instr);
        chk("R5", "skip_pulse", {31'd0, skip_pulse}, {31'd0, fv && skip});
        chk("R3", "armed", {31'd0, armed}, {31'd0, m_armed});
        chk("R3", "armed_pulse", {31'd0, armed_pulse}, {31'd0, arm_now});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R3 watchdog: got running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            e_valid[i] = 0; e_addr[i] = '0; e_nact[i] = 0;
            for (int s = 0; s < 4; s++) begin
                e_kind[i][s] = 0; e_cnt[i][s] = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "armed", {31'd0, armed}, 32'd0);
        chk("R1", "armed_pulse", {31'd0, armed_pulse}, 32'd0);
        chk("R1", "skip_pulse", {31'd0, skip_pulse}, 32'd0);
        chk("R1", "issue_valid", {31'd0, issue_valid}, 32'd0);
        chk("R1", "issue_instr", issue_instr, 32'h0000_0013);

        // Trigger and table set-up (R2), header count 9 clipped to 4.
        cfg_write(2'd0, 0, 0, 0, 32'h100, 2);
        cfg_write(2'd1, 0, 0, 0, 32'h108, 0);
        cfg_write(2'd1, 1, 0, 0, 32'h110, 3);
        cfg_write(2'd2, 1, 0, 1, 32'h0, 1);
        cfg_write(2'd2, 1, 1, 0, 32'h0, 2);
        cfg_write(2'd2, 1, 2, 1, 32'h0, 2);
        cfg_write(2'd1, 2, 0, 0, 32'h110, 0);
        cfg_write(2'd1, 3, 0, 0, 32'h118, 2);
        cfg_write(2'd2, 3, 0, 1, 32'h0, 0);
        cfg_write(2'd2, 3, 1, 0, 32'h0, 1);
        cfg_write(2'd1, 4, 0, 0, 32'h11C, 1);
        cfg_write(2'd2, 4, 0, 0, 32'h0, 3);
        cfg_write(2'd1, 5, 0, 0, 32'h104, 9);
        for (int s = 0; s < 4; s++) cfg_write(2'd2, 5, s, (s % 2) == 0, 32'h0, 1);

        for (int p = 0; p < 8; p++) begin
            if (p == 3) begin
                // R2: writes while armed must leave behaviour unchanged
                cfg_write(2'd1, 0, 0, 0, 32'h300, 1);
                cfg_write(2'd0, 0, 0, 0, 32'h104, 1);
                post_cfg = 1;
            end
            for (int a = 0; a < 8; a++) step(1'b1, 32'h100 + 32'(4 * a));
            step(1'b0, 32'h0);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule